// File: doc/BRIEF.md
# Charge Pump Gain Controller

This block chooses the voltage gain of a switched-capacitor LED supply. The three settings are x1, x1.5 and x2. The block runs on the system clock. All of its decisions happen on clock edges where a one-cycle strobe from a 1 MHz timebase is high. It reads three sampled inputs:

- a 12-bit supply code in millivolts;
- a flag that is high when any enabled LED current sink is short of headroom;
- a flag that is high when the pump output has reached its target.

From these it drives the gain select, a soft-start request and a ready flag. An under-voltage lockout with hysteresis keeps the pump idle on a weak supply. The gain rises one level when headroom stays short for several consecutive ticks. At x1 the gain also rises at once when the supply falls below the step-up threshold. The gain falls one level only after the supply has stayed above the higher return threshold for a long run of ticks.

Soft-start is requested at power-up and again after every gain change. It lasts until the output reports it is on target. While soft-start runs, no new gain change is accepted.

The state machine has four states:

| State | Meaning |
|---|---|
| IDLE | Pump stopped, gain x1 |
| PWRUP | Power-up soft-start |
| RUN | Settled and making decisions |
| RESTEP | Soft-start after a gain change |

Its transitions are:

- **IDLE→PWRUP**: the lockout is armed.
- **PWRUP→RUN** and **RESTEP→RUN**: output on target.
- **RUN→RESTEP**: a step up or a step down.
- **PWRUP / RUN / RESTEP→IDLE**: the lockout is disarmed.
- **any→IDLE**: enable is low.

Top module: `cpg_top`

## Requirements
- R1: While `en` is low, every internal state is cleared on the next clock edge, with or without a tick. The outputs are then `gain`=0, `ss_req`=0 and `ready`=0. The same holds during reset.
- R2: State, gain and the lockout flag change only on clock edges where `tick` is high (apart from R1). Input changes between ticks have no effect.
- R3: The lockout flag arms on a tick where `vin_mv` >= UV_ON_MV (2000). It disarms on a tick where `vin_mv` < UV_OFF_MV (1900). It holds between the two. The state machine leaves IDLE for PWRUP on the tick after the tick that arms the flag.
- R4: In PWRUP, `ss_req`=1 and `ready`=0. On a tick with `out_ok`=1 the block enters RUN, where `ss_req`=0 and `ready`=1.
- R5: The gain is encoded as 0 = x1, 1 = x1.5, 2 = x2. In RUN, the gain steps up exactly one level on the UP_TICKS-th (4th) consecutive tick with `hdrm_low`=1. A tick with `hdrm_low`=0 restarts that count.
- R6: In RUN at x1, a single tick with `vin_mv` < UP_MV (3650) steps the gain to x1.5.
- R7: In RUN, the gain steps down exactly one level on the DN_TICKS-th (32nd) consecutive tick with `vin_mv` >= DN_MV (3900) and `hdrm_low`=0. At x1 no step down happens.
- R8: At x2 no step up happens, however long headroom stays low.
- R9: Every gain change enters RESTEP, where `ss_req`=1 and `ready`=0. The gain is frozen there, and step triggers are ignored, until a tick with `out_ok`=1 returns the block to RUN.
- R10: If the lockout flag is clear on a tick in PWRUP, RUN or RESTEP, the block returns to IDLE with gain x1. Because the flag itself is registered, this is the tick after the disarming tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at 1 MHz; all decisions are taken on it |
| en | input | 1 | Chip enable; low clears the block |
| vin_mv | input | 12 | Sampled supply voltage in millivolts |
| hdrm_low | input | 1 | Some enabled LED sink lacks headroom |
| out_ok | input | 1 | Pump output has reached its target |
| gain | output | 2 | Selected gain: 0 = x1, 1 = x1.5, 2 = x2 |
| ss_req | output | 1 | Soft-start request to the pump |
| ready | output | 1 | Pump settled in RUN |

## Verification
The assertions assume that `tick` is a single-cycle pulse. They also assume that `vin_mv`, `hdrm_low` and `out_ok` are already synchronous samples that are steady around each ticking edge. The stimulus meets this by changing every input on the falling clock edge and raising `tick` for exactly one cycle at a time. It also includes stretches where the inputs move with no tick, to show those changes are ignored. The bench assumes that `en` may drop at any clock edge. It therefore checks the cleared state one clock after `en` falls, with no tick in between.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic [1:0] {
        GAIN_X1  = 2'd0,
        GAIN_X15 = 2'd1,
        GAIN_X2  = 2'd2
    } gain_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PWRUP  = 2'd1,
        ST_RUN    = 2'd2,
        ST_RESTEP = 2'd3
    } state_e;

endpackage

// File: rtl/cpg_uvlo.sv
module cpg_uvlo #(
    parameter int VW     = 12,
    parameter int ON_MV  = 2000,
    parameter int OFF_MV = 1900
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic [VW-1:0] vin_mv,
    output logic          armed
);
    localparam logic [VW-1:0] ON_C  = VW'(ON_MV);
    localparam logic [VW-1:0] OFF_C = VW'(OFF_MV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (!en) begin
            armed <= 1'b0;
        end else if (tick) begin
            if (vin_mv >= ON_C) begin
                armed <= 1'b1;
            end else if (vin_mv < OFF_C) begin
                armed <= 1'b0;
            end
        end
    end

    // R3: arm, disarm and hold between thresholds
    a_r3_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && vin_mv >= ON_C) |=> armed);
    a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && vin_mv < OFF_C) |=> !armed);
    a_r3_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (!tick || (vin_mv < ON_C && vin_mv >= OFF_C))) |=> $stable(armed));

endmodule

// File: rtl/cpg_persist.sv
module cpg_persist #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic cond,
    output logic hit
);
    localparam int            CW   = (N < 2) ? 1 : $clog2(N);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            if (!cond) begin
                cnt <= '0;
            end else if (cnt != LAST) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign hit = tick && cond && (cnt == LAST);

    // R5 / R7: a gap in the condition restarts the run
    a_r5_gap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && !cond) |=> (cnt == '0));
    a_r7_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/cpg_top.sv
module cpg_top #(
    parameter int VW        = 12,
    parameter int UP_MV     = 3650,
    parameter int DN_MV     = 3900,
    parameter int UV_ON_MV  = 2000,
    parameter int UV_OFF_MV = 1900,
    parameter int UP_TICKS  = 4,
    parameter int DN_TICKS  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic [VW-1:0] vin_mv,
    input  logic          hdrm_low,
    input  logic          out_ok,
    output logic [1:0]    gain,
    output logic          ss_req,
    output logic          ready
);
    import cpg_pkg::*;

    localparam logic [VW-1:0] UP_C = VW'(UP_MV);
    localparam logic [VW-1:0] DN_C = VW'(DN_MV);

    state_e state_q, state_d;
    gain_e  gain_q,  gain_d;
    logic   uv_ok;
    logic   cnt_clr;
    logic   up_hit, dn_hit;
    logic   step_up, step_dn;

    cpg_uvlo #(.VW(VW), .ON_MV(UV_ON_MV), .OFF_MV(UV_OFF_MV)) u_uvlo (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .vin_mv(vin_mv), .armed(uv_ok)
    );

    assign cnt_clr = !en || (state_q != ST_RUN);

    cpg_persist #(.N(UP_TICKS)) u_up_run (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
        .cond(hdrm_low), .hit(up_hit)
    );

    cpg_persist #(.N(DN_TICKS)) u_dn_run (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
        .cond(!hdrm_low && (vin_mv >= DN_C)), .hit(dn_hit)
    );

    assign step_up = (gain_q != GAIN_X2) &&
                     (up_hit || (tick && gain_q == GAIN_X1 && vin_mv < UP_C));
    assign step_dn = (gain_q != GAIN_X1) && dn_hit;

    // next state and gain
    always_comb begin
        state_d = state_q;
        gain_d  = gain_q;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    gain_d = GAIN_X1;
                    if (uv_ok) state_d = ST_PWRUP;
                end
                ST_PWRUP: begin
                    if (!uv_ok) begin
                        state_d = ST_IDLE;
                        gain_d  = GAIN_X1;
                    end else if (out_ok) begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!uv_ok) begin
                        state_d = ST_IDLE;
                        gain_d  = GAIN_X1;
                    end else if (step_up) begin
                        state_d = ST_RESTEP;
                        gain_d  = gain_e'(gain_q + 2'd1);
                    end else if (step_dn) begin
                        state_d = ST_RESTEP;
                        gain_d  = gain_e'(gain_q - 2'd1);
                    end
                end
                ST_RESTEP: begin
                    if (!uv_ok) begin
                        state_d = ST_IDLE;
                        gain_d  = GAIN_X1;
                    end else if (out_ok) begin
                        state_d = ST_RUN;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gain_q  <= GAIN_X1;
        end else if (!en) begin
            state_q <= ST_IDLE;
            gain_q  <= GAIN_X1;
        end else begin
            state_q <= state_d;
            gain_q  <= gain_d;
        end
    end

    // outputs
    always_comb begin
        gain   = gain_q;
        ss_req = 1'b0;
        ready  = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin ss_req = 1'b0; ready = 1'b0; end
            ST_PWRUP:  begin ss_req = 1'b1; ready = 1'b0; end
            ST_RUN:    begin ss_req = 1'b0; ready = 1'b1; end
            ST_RESTEP: begin ss_req = 1'b1; ready = 1'b0; end
        endcase
    end

    // R1: enable low clears state and gain on the next edge
    a_r1_en_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_IDLE && gain_q == GAIN_X1));
    // R2: nothing moves without a tick
    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> ($stable(state_q) && $stable(gain_q)));
    // R9: gain frozen during soft-start while supply is good
    a_r9_ss_gain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ss_req && uv_ok) |=> $stable(gain_q));
    // R5: gain moves by at most one level unless sent back to x1
    a_r5_single_level: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (gain_q == $past(gain_q) || gain_q == GAIN_X1 ||
                2'(gain_q - $past(gain_q)) == 2'd1 ||
                2'($past(gain_q) - gain_q) == 2'd1));
    // R10: lost lockout sends the block to IDLE at x1
    a_r10_uvlo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !uv_ok) |=> (state_q == ST_IDLE && gain_q == GAIN_X1));

endmodule

// File: tb/sim_cpg_top.sv
module sim_cpg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        en = 1'b0;
    logic [11:0] vin_mv = 12'd0;
    logic        hdrm_low = 1'b0;
    logic        out_ok = 1'b0;
    logic [1:0]  gain;
    logic        ss_req;
    logic        ready;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cpg_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .vin_mv(vin_mv),
        .hdrm_low(hdrm_low), .out_ok(out_ok),
        .gain(gain), .ss_req(ss_req), .ready(ready)
    );

    // en, vin, hdrm, ok | expected gain, ss, ready
    localparam int NV = 16;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 12'd3700, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}, // R3 arm, still idle
        {1'b1, 12'd3700, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0}, // R4 power-up
        {1'b1, 12'd3700, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0}, // R4 wait
        {1'b1, 12'd3700, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1}, // R4 run
        {1'b1, 12'd3700, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1}, // R5 count 1
        {1'b1, 12'd3700, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1}, // R5 count 2
        {1'b1, 12'd3700, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1}, // R5 gap
        {1'b1, 12'd3700, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1},
        {1'b1, 12'd3700, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1},
        {1'b1, 12'd3700, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1},
        {1'b1, 12'd3700, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0}, // R5 fourth tick steps
        {1'b1, 12'd3700, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0}, // R9 frozen
        {1'b1, 12'd3600, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0}, // R9 frozen
        {1'b1, 12'd3700, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1}, // R9 back to run
        {1'b1, 12'd3600, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1}, // R6 only at x1
        {1'b1, 12'd3600, 1'b1, 1'b1, 2'd1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [1:0] eg,
                       input logic ess, input logic erd);
        checks++;
        if (gain !== eg || ss_req !== ess || ready !== erd) begin
            failures++;
            $display("FAIL %s: gain=%0d ss=%0b rdy=%0b expected gain=%0d ss=%0b rdy=%0b",
                     req, gain, ss_req, ready, eg, ess, erd);
        end
    endtask

    task automatic set_in(input logic e, input logic [11:0] v,
                          input logic h, input logic o);
        en = e; vin_mv = v; hdrm_low = h; out_ok = o;
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 2'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 2'd0, 1'b0, 1'b0);

        for (int k = 0; k < NV; k++) begin
            set_in(VEC[k][18], VEC[k][17:6], VEC[k][5], VEC[k][4]);
            tick_once();
            chk($sformatf("R3-table row %0d", k), VEC[k][3:2], VEC[k][1], VEC[k][0]);
        end

        // R7 step down after 32 ticks
        set_in(1'b1, 12'd4000, 1'b0, 1'b1);
        ticks(31);
        chk("R7 before 32nd tick", 2'd1, 1'b0, 1'b1);
        tick_once();
        chk("R7 step down", 2'd0, 1'b1, 1'b0);
        tick_once();
        chk("R9 settle", 2'd0, 1'b0, 1'b1);
        ticks(40);
        chk("R7 floor at x1", 2'd0, 1'b0, 1'b1);

        // R6 low supply at x1
        set_in(1'b1, 12'd3600, 1'b0, 1'b1);
        tick_once();
        chk("R6 low supply step", 2'd1, 1'b1, 1'b0);
        set_in(1'b1, 12'd3700, 1'b0, 1'b1);
        tick_once();
        chk("R6 settle", 2'd1, 1'b0, 1'b1);

        // up to x2, then saturation
        set_in(1'b1, 12'd3700, 1'b1, 1'b1);
        ticks(4);
        chk("R5 step to x2", 2'd2, 1'b1, 1'b0);
        tick_once();
        ticks(6);
        chk("R8 ceiling at x2", 2'd2, 1'b0, 1'b1);

        // R2 no tick: inputs move, nothing changes
        set_in(1'b1, 12'd1000, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        chk("R2 no tick", 2'd2, 1'b0, 1'b1);

        // step down from x2
        set_in(1'b1, 12'd4000, 1'b0, 1'b1);
        ticks(32);
        chk("R7 x2 to x1.5", 2'd1, 1'b1, 1'b0);
        tick_once();
        chk("R7 settle", 2'd1, 1'b0, 1'b1);

        // lockout hysteresis
        set_in(1'b1, 12'd1950, 1'b0, 1'b1);
        ticks(3);
        chk("R3 inside band holds", 2'd1, 1'b0, 1'b1);
        set_in(1'b1, 12'd1899, 1'b0, 1'b1);
        tick_once();
        chk("R10 one tick latency", 2'd1, 1'b0, 1'b1);
        tick_once();
        chk("R10 idle on lockout", 2'd0, 1'b0, 1'b0);
        set_in(1'b1, 12'd1950, 1'b0, 1'b1);
        ticks(5);
        chk("R3 band does not arm", 2'd0, 1'b0, 1'b0);
        set_in(1'b1, 12'd2000, 1'b0, 1'b0);
        tick_once();
        chk("R3 arm tick", 2'd0, 1'b0, 1'b0);
        tick_once();
        chk("R4 power-up again", 2'd0, 1'b1, 1'b0);

        // R1 enable low clears without tick
        set_in(1'b0, 12'd2000, 1'b0, 1'b0);
        @(negedge clk);
        chk("R1 enable low", 2'd0, 1'b0, 1'b0);
        set_in(1'b1, 12'd3700, 1'b0, 1'b1);
        tick_once();
        chk("R1 restart from idle", 2'd0, 1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule